// File: doc/BRIEF.md
# Operand Address Resolver with Status Word

This block converts an instruction's decoded operand description into a concrete memory target for a small 8-bit microcontroller core. Each request carries an addressing-mode code, the three-bit register field from the opcode, a direct address byte, the stack pointer and the 16-bit data pointer. The block answers with a target space (internal RAM, special-function registers, external data, or none) and the resolved address. For pointer-register indirection it issues a read address into the working register file. The register file returns the pointer byte in the same cycle.

The block also holds the program status word. Software writes the carry, auxiliary carry, overflow, user flag and two bank-select bits. Hardware reloads the parity bit on every clock from the accumulator. The two bank-select bits choose which group of eight working registers register-mode and pointer-mode operands use.

Requests enter on a valid/ready handshake and results leave on a second one, through a single register stage. A request is accepted when `in_valid` and `in_ready` are both high on a clock edge. `in_ready` is high whenever the output stage is empty or its result is being taken in that cycle. A result offered with `out_ready` low stays unchanged until it is taken. The status-word pins and the pointer-read pins use no handshake.

Top module: `opaddr_resolver`

## Requirements
- R1: Mode code 0 (register) resolves to space 0 (internal RAM) at address {RS1, RS0, field}, where RS1 is status bit 4, RS0 is status bit 3 and field is `in_reg_fld`.
- R2: Mode code 1 (direct) with a byte below 80h resolves to space 0 at that byte.
- R3: Mode code 1 with a byte of 80h or above resolves to space 1 (special-function registers) at that byte.
- R4: Mode code 2 (pointer-register indirect) drives `ptr_rd_addr` = {000, RS1, RS0, 00, `in_reg_fld[0]`}. It resolves to space 0 at the returned byte, over the full 00h–FFh range.
- R5: Mode code 3 (stack-pointer indirect) resolves to space 0 at `in_sp`.
- R6: Mode code 4 (data-pointer indirect) resolves to space 2 (external data) at the full 16-bit `in_dptr`.
- R7: Mode codes 5, 6 and 7 resolve to space 3 (none) with address 0.
- R8: Status bit 0 equals the XOR of all accumulator bits sampled at the previous clock edge.
- R9: A status write sets bits 7..2 from `psw_wr_data[7:2]` at the next edge. The write cannot change bit 0, and bit 1 always reads 0. A request accepted in the same cycle still uses the old bank.
- R10: After reset the status word is 00h and `out_valid` is low.
- R11: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the result and its space hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_mode | input | 3 | Addressing-mode code |
| in_reg_fld | input | 3 | Register field from the opcode |
| in_direct | input | 8 | Direct address byte |
| in_sp | input | 8 | Stack pointer value |
| in_dptr | input | 16 | Data pointer value |
| ptr_rd_addr | output | 8 | Register-file read address for the pointer register |
| ptr_rd_data | input | 8 | Pointer register content returned in the same cycle |
| acc | input | 8 | Accumulator value for parity |
| psw_wr_en | input | 1 | Software write strobe for the status word |
| psw_wr_data | input | 8 | Status word write data |
| psw_q | output | 8 | Current status word |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_space | output | 2 | Target space code |
| out_addr | output | 16 | Resolved address |

## Verification
The bench builds the block with its default widths: an 8-bit byte and a 16-bit external address. With these widths, every bank value, the 7Fh/80h direct split and full-width data-pointer addresses can be tested. A pseudo-random consumer stalls the output stage, so requests meet back-pressure in many different cycles. Status-word writes are interleaved with requests so that all four banks feed register-mode and pointer-mode resolution.

// File: rtl/ares_pkg.sv
package ares_pkg;
  localparam int BYTE_W  = 8;
  localparam int MODE_W  = 3;
  localparam int SPACE_W = 2;

  localparam logic [MODE_W-1:0] MODE_REG  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_DIR  = 3'd1;
  localparam logic [MODE_W-1:0] MODE_PTR  = 3'd2;
  localparam logic [MODE_W-1:0] MODE_STK  = 3'd3;
  localparam logic [MODE_W-1:0] MODE_XPTR = 3'd4;

  localparam logic [SPACE_W-1:0] SP_IRAM = 2'd0;
  localparam logic [SPACE_W-1:0] SP_SFR  = 2'd1;
  localparam logic [SPACE_W-1:0] SP_XDAT = 2'd2;
  localparam logic [SPACE_W-1:0] SP_NONE = 2'd3;

  // Status word bit positions (bank bits are decoded by the resolver)
  localparam int ST_PAR  = 0;
  localparam int ST_RSV  = 1;
  localparam int ST_BANK = 3;
  localparam int ST_HI   = 2;
endpackage

// File: rtl/ares_psw_reg.sv
module ares_psw_reg
  import ares_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] acc,
  output logic [W-1:0] psw,
  output logic [1:0]   bank
);
  localparam int SW_W = W - ST_HI;

  logic [SW_W-1:0] sw_q;
  logic            par_q;
  logic            unused_lo;

  assign unused_lo = ^wr_data[ST_HI-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q  <= '0;
      par_q <= 1'b0;
    end else begin
      par_q <= ^acc;
      if (wr_en) sw_q <= wr_data[W-1:ST_HI];
    end
  end

  assign psw  = {sw_q, 1'b0, par_q};
  assign bank = psw[ST_BANK+1:ST_BANK];
endmodule

// File: rtl/ares_resolve.sv
module ares_resolve
  import ares_pkg::*;
#(
  parameter int W  = BYTE_W,
  parameter int XW = 16
) (
  input  logic [MODE_W-1:0]  mode,
  input  logic [2:0]         reg_fld,
  input  logic [W-1:0]       direct,
  input  logic [W-1:0]       sp,
  input  logic [XW-1:0]      dptr,
  input  logic [1:0]         bank,
  output logic [W-1:0]       ptr_addr,
  input  logic [W-1:0]       ptr_data,
  output logic [SPACE_W-1:0] space,
  output logic [XW-1:0]      addr
);
  localparam int PAD = XW - W;
  localparam int BPAD = W - 5;

  logic [W-1:0] reg_addr;

  assign reg_addr = {{BPAD{1'b0}}, bank, reg_fld};
  assign ptr_addr = {{BPAD{1'b0}}, bank, 2'b00, reg_fld[0]};

  always_comb begin
    space = SP_NONE;
    addr  = '0;
    case (mode)
      MODE_REG: begin
        space = SP_IRAM;
        addr  = {{PAD{1'b0}}, reg_addr};
      end
      MODE_DIR: begin
        space = direct[W-1] ? SP_SFR : SP_IRAM;
        addr  = {{PAD{1'b0}}, direct};
      end
      MODE_PTR: begin
        space = SP_IRAM;
        addr  = {{PAD{1'b0}}, ptr_data};
      end
      MODE_STK: begin
        space = SP_IRAM;
        addr  = {{PAD{1'b0}}, sp};
      end
      MODE_XPTR: begin
        space = SP_XDAT;
        addr  = dptr;
      end
      default: begin
        space = SP_NONE;
        addr  = '0;
      end
    endcase
  end
endmodule

// File: rtl/ares_out_stage.sv
module ares_out_stage #(
  parameter int PW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i_valid,
  output logic          i_ready,
  input  logic [PW-1:0] i_data,
  output logic          o_valid,
  input  logic          o_ready,
  output logic [PW-1:0] o_data
);
  logic          v_q;
  logic [PW-1:0] d_q;

  assign i_ready = !v_q || o_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else if (i_ready) begin
      v_q <= i_valid;
      if (i_valid) d_q <= i_data;
    end
  end

  assign o_valid = v_q;
  assign o_data  = d_q;
endmodule

// File: rtl/opaddr_resolver.sv
module opaddr_resolver
  import ares_pkg::*;
#(
  parameter int W  = BYTE_W,
  parameter int XW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [MODE_W-1:0]  in_mode,
  input  logic [2:0]         in_reg_fld,
  input  logic [W-1:0]       in_direct,
  input  logic [W-1:0]       in_sp,
  input  logic [XW-1:0]      in_dptr,
  output logic [W-1:0]       ptr_rd_addr,
  input  logic [W-1:0]       ptr_rd_data,
  input  logic [W-1:0]       acc,
  input  logic               psw_wr_en,
  input  logic [W-1:0]       psw_wr_data,
  output logic [W-1:0]       psw_q,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [SPACE_W-1:0] out_space,
  output logic [XW-1:0]      out_addr
);
  localparam int PW = SPACE_W + XW;

  logic [1:0]         bank;
  logic [SPACE_W-1:0] res_space;
  logic [XW-1:0]      res_addr;
  logic [PW-1:0]      res_pay, out_pay;

  ares_psw_reg #(.W(W)) u_psw (
    .clk(clk), .rst_n(rst_n), .wr_en(psw_wr_en), .wr_data(psw_wr_data),
    .acc(acc), .psw(psw_q), .bank(bank)
  );

  ares_resolve #(.W(W), .XW(XW)) u_res (
    .mode(in_mode), .reg_fld(in_reg_fld), .direct(in_direct), .sp(in_sp),
    .dptr(in_dptr), .bank(bank), .ptr_addr(ptr_rd_addr),
    .ptr_data(ptr_rd_data), .space(res_space), .addr(res_addr)
  );

  assign res_pay = {res_space, res_addr};

  ares_out_stage #(.PW(PW)) u_out (
    .clk(clk), .rst_n(rst_n), .i_valid(in_valid), .i_ready(in_ready),
    .i_data(res_pay), .o_valid(out_valid), .o_ready(out_ready),
    .o_data(out_pay)
  );

  assign out_space = out_pay[PW-1:XW];
  assign out_addr  = out_pay[XW-1:0];
endmodule

// File: rtl/ares_checker.sv
module ares_checker #(
  parameter int W  = 8,
  parameter int XW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [2:0]    in_mode,
  input logic [W-1:0]  in_direct,
  input logic [XW-1:0] in_dptr,
  input logic [W-1:0]  ptr_rd_addr,
  input logic [W-1:0]  acc,
  input logic          psw_wr_en,
  input logic [W-1:0]  psw_wr_data,
  input logic [W-1:0]  psw_q,
  input logic          out_valid,
  input logic          out_ready,
  input logic [1:0]    out_space,
  input logic [XW-1:0] out_addr
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_space)); // R11
  AST_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> psw_q[0] == ^$past(acc)); // R8
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    psw_q[1] == 1'b0); // R9
  AST_PSW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    psw_wr_en |=> psw_q[W-1:2] == $past(psw_wr_data[W-1:2])); // R9
  AST_PTR_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rd_addr[4:3] == psw_q[4:3] && ptr_rd_addr[2:1] == 2'b00); // R4
  AST_XDATA: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_mode == 3'd4 |=> out_space == 2'd2 && out_addr == $past(in_dptr)); // R6
  AST_SFR_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_mode == 3'd1 |=> out_space == ($past(in_direct[W-1]) ? 2'd1 : 2'd0)); // R3
endmodule

bind opaddr_resolver ares_checker #(.W(W), .XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_mode(in_mode), .in_direct(in_direct), .in_dptr(in_dptr),
  .ptr_rd_addr(ptr_rd_addr), .acc(acc), .psw_wr_en(psw_wr_en),
  .psw_wr_data(psw_wr_data), .psw_q(psw_q), .out_valid(out_valid),
  .out_ready(out_ready), .out_space(out_space), .out_addr(out_addr)
);

// File: tb/test_opaddr_resolver.sv
module test_opaddr_resolver;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_mode = '0;
  logic [2:0]  in_reg_fld = '0;
  logic [7:0]  in_direct = '0;
  logic [7:0]  in_sp = '0;
  logic [15:0] in_dptr = '0;
  logic [7:0]  ptr_rd_addr;
  logic [7:0]  ptr_rd_data;
  logic [7:0]  acc = '0;
  logic        psw_wr_en = 1'b0;
  logic [7:0]  psw_wr_data = '0;
  logic [7:0]  psw_q;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_space;
  logic [15:0] out_addr;

  int n_checks = 0;
  int n_errs = 0;
  bit done = 0;
  bit stall_en = 0;
  logic [7:0] rf [32];
  logic [1:0] cur_bank = '0;
  logic [7:0] lfsr = 8'h5a;

  logic [1:0]  q_space [$];
  logic [15:0] q_addr [$];
  string       q_tag [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ptr_rd_data = rf[ptr_rd_addr[4:0]];

  opaddr_resolver i_opaddr_resolver (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // consumer back-pressure
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = stall_en ? lfsr[0] : 1'b1;
  end

  // monitor: pops expected results, checks hold under stall
  logic        held = 0;
  logic [1:0]  h_space;
  logic [15:0] h_addr;
  always @(negedge clk) begin
    if (rst_n) begin
      check(in_ready == (!out_valid || out_ready), "R11", "in_ready", in_ready, !out_valid || out_ready);
      if (held) begin
        check(out_valid && out_space == h_space && out_addr == h_addr, "R11", "held result",
              {out_space, out_addr}, {h_space, h_addr});
      end
      held = out_valid && !out_ready;
      h_space = out_space;
      h_addr = out_addr;
      if (out_valid && out_ready) begin
        if (q_space.size() == 0) begin
          check(0, "R11", "unexpected result", out_addr, 0);
        end else begin
          logic [1:0] es;
          logic [15:0] ea;
          string t;
          es = q_space.pop_front();
          ea = q_addr.pop_front();
          t = q_tag.pop_front();
          check(out_space == es && out_addr == ea, t, "space/addr", {out_space, out_addr}, {es, ea});
        end
      end
    end
  end

  task automatic send(input logic [2:0] m, input logic [2:0] f, input logic [7:0] d,
                      input logic [7:0] s, input logic [15:0] x,
                      input logic [1:0] es, input logic [15:0] ea, input string tag);
    @(posedge clk); #2;
    in_valid = 1; in_mode = m; in_reg_fld = f; in_direct = d; in_sp = s; in_dptr = x;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    q_space.push_back(es); q_addr.push_back(ea); q_tag.push_back(tag);
    @(posedge clk); #2;
    in_valid = 0;
  endtask

  task automatic drain();
    int guard = 0;
    while (q_space.size() != 0 && guard < 200) begin
      @(posedge clk);
      guard++;
    end
  endtask

  task automatic psw_write(input logic [7:0] v);
    drain();
    @(posedge clk); #2;
    psw_wr_en = 1; psw_wr_data = v;
    @(posedge clk); #2;
    psw_wr_en = 0;
    cur_bank = v[4:3];
    @(negedge clk);
    check(psw_q[7:2] == v[7:2], "R9", "psw high bits", psw_q, v);
    check(psw_q[1] == 1'b0, "R9", "reserved bit", psw_q[1], 0);
    check(psw_q[0] == ^acc, "R9", "parity not writable", psw_q[0], ^acc);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_errs++; n_checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 8'(i * 37 + 11);
    rf[0] = 8'hff; rf[9] = 8'h80; rf[17] = 8'h00;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    check(psw_q == 8'h00, "R10", "psw after reset", psw_q, 0);
    check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);

    for (int pass = 0; pass < 2; pass++) begin
      stall_en = (pass == 1);
      for (int b = 0; b < 4; b++) begin
        psw_write({2'(b), 1'b1, 2'(b), 1'b0, 2'b11} ^ {5'd0, 3'(pass * 4)});
        for (int f = 0; f < 8; f++)
          send(3'd0, 3'(f), 8'h00, 8'h00, 16'h0, 2'd0, {11'd0, cur_bank, 3'(f)}, "R1");
        for (int f = 0; f < 2; f++)
          send(3'd2, 3'(f + 4), 8'h00, 8'h00, 16'h0, 2'd0, {8'd0, rf[{cur_bank, 2'b00, 1'(f)}]}, "R4");
        send(3'd1, 3'(b), 8'h00, 8'h00, 16'h0, 2'd0, 16'h0000, "R2");
        send(3'd1, 3'(b), 8'h7f, 8'h00, 16'h0, 2'd0, 16'h007f, "R2");
        send(3'd1, 3'(b), 8'h80, 8'h00, 16'h0, 2'd1, 16'h0080, "R3");
        send(3'd1, 3'(b), 8'hff, 8'h00, 16'h0, 2'd1, 16'h00ff, "R3");
        send(3'd3, 3'd0, 8'h00, 8'(8'h07 + b * 60), 16'h0, 2'd0, {8'd0, 8'(8'h07 + b * 60)}, "R5");
        send(3'd4, 3'd0, 8'h00, 8'h00, 16'(16'hf00d + b * 4097), 2'd2, 16'(16'hf00d + b * 4097), "R6");
        send(3'd5, 3'd7, 8'h99, 8'h55, 16'hffff, 2'd3, 16'h0000, "R7");
        send(3'd7, 3'd7, 8'h99, 8'h55, 16'hffff, 2'd3, 16'h0000, "R7");
      end
    end

    // pointer read address at the port (R4)
    drain();
    psw_write(8'h10);
    @(posedge clk); #2 in_reg_fld = 3'd1;
    @(negedge clk);
    check(ptr_rd_addr == 8'h11, "R4", "pointer read address", ptr_rd_addr, 8'h11);

    // same-cycle write and request: old bank used (R9)
    drain();
    @(posedge clk); #2;
    psw_wr_en = 1; psw_wr_data = 8'h18;
    in_valid = 1; in_mode = 3'd0; in_reg_fld = 3'd5; stall_en = 0;
    q_space.push_back(2'd0); q_addr.push_back(16'h0015); q_tag.push_back("R9");
    @(posedge clk); #2;
    psw_wr_en = 0; in_valid = 0; cur_bank = 2'd3;
    drain();

    // parity tracking (R8)
    begin
      logic [7:0] pv [6];
      pv[0] = 8'h00; pv[1] = 8'h01; pv[2] = 8'h03; pv[3] = 8'h80; pv[4] = 8'hfe; pv[5] = 8'hff;
      for (int i = 0; i < 6; i++) begin
        @(posedge clk); #2 acc = pv[i];
        @(posedge clk);
        @(negedge clk);
        check(psw_q[0] == ^pv[i], "R8", "parity bit", psw_q[0], ^pv[i]);
      end
    end

    // write trying to set P and reserved bit while acc has even parity (R9)
    @(posedge clk); #2 acc = 8'h03;
    psw_write(8'h27);

    drain();
    check(q_space.size() == 0, "R11", "all results delivered", q_space.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end
endmodule